// File: doc/BRIEF.md
# Contactless Controller Boot-Window Supervisor

This block models how a contactless controller starts up on a host byte bus. A separate I2C target front end decodes the bit-level traffic into one-cycle events: start, address byte (seven address bits followed by the read/write bit), data byte and stop. The supervisor consumes those events. It tells the front end whether to acknowledge the address phase, and it reports a start-up state code.

When the active-high enable input goes high, a timed boot window opens. Within that window the host must send a core-reset command, a single write transfer of exactly four bytes. If the command arrives in time, the block moves to its ready state, emits a one-cycle accept pulse and raises a response-pending flag. The flag stays set until the host addresses the block for a read. If the window closes first, the block drops into a power-down state that ignores the bus completely. Only a low-then-high cycle on enable brings it out.

The window length is set in clock cycles as a prescaler period times a tick count. A real part waits roughly 990 ms. A testbench can shorten the window to a few dozen cycles.

Top module: `nfcb_boot_supervisor`

## Requirements
- R1: While `boot_en` is low, `boot_state` is OFF (code 0) one cycle later, and `ack_en`, `reset_accepted` and `resp_pending` are all 0.
- R2: A cycle with `boot_en` high while the state is OFF moves the state to BOOT_WAIT (code 1) on the following cycle.
- R3: The target address is the 7-bit value {6'b010100, `addr_sel`}, i.e. 0x28 or 0x29. `ack_en` is high in the same cycle as an address event (`ev_kind` = 1) whose `ev_byte[7:1]` equals that address, for either R/W value (`ev_byte[0]`, 1 = read), and only while the state is BOOT_WAIT or READY.
- R4: The command is one transfer made of: a start (`ev_kind` 0), an address event for the target with R/W = 0, data events (`ev_kind` 2) carrying 0x20, 0x00, 0x01, 0x01, and a stop (`ev_kind` 3). When it completes during BOOT_WAIT, the state is READY (code 2) in the cycle after the stop. In that same cycle `reset_accepted` is high for exactly one cycle and `resp_pending` becomes 1. READY then persists while enable stays high.
- R5: During BOOT_WAIT, any of the following leaves the state at BOOT_WAIT and does not restart the window: a write with a wrong byte, too few bytes, too many bytes, a different address, the read bit set, or the bytes split across a repeated start.
- R6: Without a valid command, BOOT_WAIT lasts exactly PRESCALE × WINDOW_TICKS cycles, after which the state is POWER_DOWN (code 3).
- R7: POWER_DOWN holds while enable stays high. In that state `ack_en` stays 0 and a valid command produces no accept pulse and no state change.
- R8: Enable low for one cycle and then high again takes POWER_DOWN to OFF and then to BOOT_WAIT, with a full new window.
- R9: `resp_pending` clears in the cycle after a read-address event to the target while in READY. A write-address event does not clear it.
- R10: A command whose stop falls in the last cycle of the window is accepted. A stop one cycle later finds POWER_DOWN and is ignored.
- R11: A second valid command while READY gives no accept pulse and leaves the state at READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_en | input | 1 | Active-high enable; low holds the block in OFF |
| addr_sel | input | 1 | Strap that supplies the address LSB |
| ev_valid | input | 1 | A bus event is present this cycle |
| ev_kind | input | 2 | Event kind: 0 start, 1 address, 2 data, 3 stop |
| ev_byte | input | 8 | Address byte (with R/W in bit 0) or data byte |
| ack_en | output | 1 | Acknowledge the current address event |
| boot_state | output | 2 | 0 OFF, 1 BOOT_WAIT, 2 READY, 3 POWER_DOWN |
| reset_accepted | output | 1 | One-cycle pulse when the reset command is taken |
| resp_pending | output | 1 | A reset response is owed to the host |

## Verification
`ack_en` is decoded from the incoming event, so it is due in the very cycle that carries the address event. The state code, the accept pulse and the pending flag all come from registers. They therefore change one cycle after the cycle holding the stop, the enable change, the read address or the last window cycle. The bench drives every event on the falling edge, numbers each driven cycle, and files each expectation under the cycle in which its result is due. A monitor samples the ports 4 ns later, just ahead of the next rising edge. Window boundaries are placed by cycle number counted from the enable cycle, so the last-cycle and one-late stops land exactly on the edges that R6 and R10 name.

// File: rtl/nfcb_pkg.sv
package nfcb_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_WAIT  = 2'd1,
    ST_READY = 2'd2,
    ST_PDOWN = 2'd3
  } boot_st_e;

  typedef enum logic [1:0] {
    EV_START = 2'd0,
    EV_ADDR  = 2'd1,
    EV_DATA  = 2'd2,
    EV_STOP  = 2'd3
  } bus_ev_e;

  localparam int          CMD_LEN = 4;
  localparam logic [5:0]  ADDR_HI = 6'b010100;

  function automatic logic [7:0] cmd_byte(input int idx);
    logic [7:0] b;
    case (idx)
      0:       b = 8'h20;
      1:       b = 8'h00;
      2:       b = 8'h01;
      3:       b = 8'h01;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nfcb_window_timer.sv
module nfcb_window_timer #(
  parameter int PRESCALE     = 100000,
  parameter int WINDOW_TICKS = 990
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  localparam int PRE_W  = $clog2(PRESCALE + 1);
  localparam int TICK_W = $clog2(WINDOW_TICKS + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRESCALE - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(WINDOW_TICKS - 1);
  localparam logic [TICK_W-1:0] TICK_LIM  = TICK_W'(WINDOW_TICKS);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic              pre_wrap;

  always_comb begin
    pre_wrap = (pre_q == PRE_LAST);
    expire   = run && pre_wrap && (tick_q == TICK_LAST);
  end

  always_comb begin
    pre_d  = pre_q;
    tick_d = tick_q;
    if (!run || expire) begin
      pre_d  = '0;
      tick_d = '0;
    end else if (pre_wrap) begin
      pre_d  = '0;
      tick_d = tick_q + 1'b1;
    end else begin
      pre_d  = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q  <= pre_d;
      tick_q <= tick_d;
    end
  end

  // R6: tick count never reaches the window length
  p_tick_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < TICK_LIM);

  // R6: counters restart from zero whenever the window is not running
  p_idle_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0 && tick_q == '0));

endmodule

// File: rtl/nfcb_cmd_match.sv
module nfcb_cmd_match
  import nfcb_pkg::*;
#(
  parameter int LEN = CMD_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ev_valid,
  input  bus_ev_e    ev_kind,
  input  logic [7:0] ev_byte,
  input  logic [6:0] tgt_addr,
  output logic       cmd_ok
);

  localparam int CNT_W = $clog2(LEN + 2);
  localparam logic [CNT_W-1:0] LEN_V = CNT_W'(LEN);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(LEN + 1);

  logic             open_q, open_d;
  logic             armed_q, armed_d;
  logic             ok_q, ok_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             upd;

  assign upd    = ev_valid || clr;
  assign cmd_ok = ev_valid && (ev_kind == EV_STOP) && armed_q && ok_q &&
                  (idx_q == LEN_V);

  always_comb begin
    open_d  = open_q;
    armed_d = armed_q;
    ok_d    = ok_q;
    idx_d   = idx_q;
    if (clr) begin
      open_d  = 1'b0;
      armed_d = 1'b0;
      ok_d    = 1'b0;
      idx_d   = '0;
    end else if (ev_valid) begin
      case (ev_kind)
        EV_START: begin
          open_d  = 1'b1;
          armed_d = 1'b0;
          ok_d    = 1'b1;
          idx_d   = '0;
        end
        EV_ADDR: begin
          armed_d = open_q && (ev_byte[7:1] == tgt_addr) && !ev_byte[0];
          open_d  = 1'b0;
          ok_d    = 1'b1;
          idx_d   = '0;
        end
        EV_DATA: begin
          if (armed_q) begin
            if (idx_q < LEN_V)
              ok_d = ok_q && (ev_byte == cmd_byte(int'(idx_q)));
            if (idx_q != MAX_V)
              idx_d = idx_q + 1'b1;
          end
        end
        default: begin
          open_d  = 1'b0;
          armed_d = 1'b0;
          ok_d    = 1'b0;
          idx_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q  <= 1'b0;
      armed_q <= 1'b0;
      ok_q    <= 1'b0;
      idx_q   <= '0;
    end else if (upd) begin
      open_q  <= open_d;
      armed_q <= armed_d;
      ok_q    <= ok_d;
      idx_q   <= idx_d;
    end
  end

  // R5: byte index saturates one past the command length
  p_idx_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= MAX_V);

  // R4: a completed command closes the transfer
  p_ok_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ok |=> !armed_q);

endmodule

// File: rtl/nfcb_boot_fsm.sv
module nfcb_boot_fsm
  import nfcb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     cmd_ok,
  input  logic     expire,
  input  logic     rd_hit,
  output boot_st_e state_o,
  output logic     accept_o,
  output logic     pend_o,
  output logic     run_o
);

  boot_st_e state_q, state_d;
  logic     accept_q, accept_d;
  logic     pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = ST_OFF;
    end else begin
      case (state_q)
        ST_OFF:   state_d = ST_WAIT;
        ST_WAIT: begin
          if (cmd_ok)      state_d = ST_READY;
          else if (expire) state_d = ST_PDOWN;
        end
        ST_READY: state_d = ST_READY;
        default:  state_d = ST_PDOWN;
      endcase
    end
  end

  always_comb begin
    accept_d = en && (state_q == ST_WAIT) && cmd_ok;
    pend_d   = pend_q;
    if (!en)
      pend_d = 1'b0;
    else if (accept_d)
      pend_d = 1'b1;
    else if (rd_hit && state_q == ST_READY)
      pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OFF;
      accept_q <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      accept_q <= accept_d;
      pend_q   <= pend_d;
    end
  end

  assign state_o  = state_q;
  assign accept_o = accept_q;
  assign pend_o   = pend_q;
  assign run_o    = (state_q == ST_WAIT);

  // R1: enable low forces OFF on the next cycle
  p_off_when_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == ST_OFF);

  // R7: power-down persists while enable stays high
  p_pdown_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PDOWN && en) |=> state_q == ST_PDOWN);

  // R4: accept pulse lasts one cycle
  p_accept_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_q |=> !accept_q);

  // R4: accept coincides with READY and a pending response
  p_accept_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_q |-> (state_q == ST_READY && pend_q));

  // R5: waiting continues unless a command or expiry occurs
  p_wait_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && en && !cmd_ok && !expire) |=> state_q == ST_WAIT);

  // R11: READY never produces a further accept
  p_ready_no_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY && en) |=> !accept_q);

endmodule

// File: rtl/nfcb_boot_supervisor.sv
module nfcb_boot_supervisor
  import nfcb_pkg::*;
#(
  parameter int PRESCALE     = 100000,
  parameter int WINDOW_TICKS = 990
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boot_en,
  input  logic       addr_sel,
  input  logic       ev_valid,
  input  logic [1:0] ev_kind,
  input  logic [7:0] ev_byte,
  output logic       ack_en,
  output logic [1:0] boot_state,
  output logic       reset_accepted,
  output logic       resp_pending
);

  logic [6:0] tgt_addr;
  logic       addr_match;
  logic       rd_hit;
  logic       cmd_ok;
  logic       expire;
  logic       run;
  boot_st_e   st;
  bus_ev_e    kind;

  assign kind       = bus_ev_e'(ev_kind);
  assign tgt_addr   = {ADDR_HI, addr_sel};
  assign addr_match = ev_valid && (kind == EV_ADDR) && (ev_byte[7:1] == tgt_addr);
  assign rd_hit     = addr_match && ev_byte[0];
  assign ack_en     = addr_match && ((st == ST_WAIT) || (st == ST_READY));
  assign boot_state = st;

  nfcb_cmd_match #(.LEN(CMD_LEN)) u_match (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (!boot_en),
    .ev_valid (ev_valid),
    .ev_kind  (kind),
    .ev_byte  (ev_byte),
    .tgt_addr (tgt_addr),
    .cmd_ok   (cmd_ok)
  );

  nfcb_window_timer #(
    .PRESCALE     (PRESCALE),
    .WINDOW_TICKS (WINDOW_TICKS)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .expire (expire)
  );

  nfcb_boot_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (boot_en),
    .cmd_ok   (cmd_ok),
    .expire   (expire),
    .rd_hit   (rd_hit),
    .state_o  (st),
    .accept_o (reset_accepted),
    .pend_o   (resp_pending),
    .run_o    (run)
  );

  // R7: no acknowledge in power-down
  p_no_ack_pdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PDOWN) |-> !ack_en);

  // R1: no acknowledge and no pending response while OFF
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF) |-> (!ack_en && !resp_pending && !reset_accepted));

endmodule

// File: tb/tb_nfcb_boot_supervisor.sv
module tb_nfcb_boot_supervisor;

  localparam int PS = 4;
  localparam int WT = 25;
  localparam int W  = PS * WT;

  localparam logic [1:0] K_START = 2'd0;
  localparam logic [1:0] K_ADDR  = 2'd1;
  localparam logic [1:0] K_DATA  = 2'd2;
  localparam logic [1:0] K_STOP  = 2'd3;

  logic       clk;
  logic       rst_n;
  logic       boot_en;
  logic       addr_sel;
  logic       ev_valid;
  logic [1:0] ev_kind;
  logic [7:0] ev_byte;
  logic       ack_en;
  logic [1:0] boot_state;
  logic       reset_accepted;
  logic       resp_pending;

  nfcb_boot_supervisor #(.PRESCALE(PS), .WINDOW_TICKS(WT)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .boot_en        (boot_en),
    .addr_sel       (addr_sel),
    .ev_valid       (ev_valid),
    .ev_kind        (ev_kind),
    .ev_byte        (ev_byte),
    .ack_en         (ack_en),
    .boot_state     (boot_state),
    .reset_accepted (reset_accepted),
    .resp_pending   (resp_pending)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    checks = 0;
  int    fails  = 0;
  int    now    = 0;
  bit    done   = 0;
  string q_req[$];
  logic [4:0] q_val[$];

  // scoreboard monitor: compares queued expectations just before the next rising edge
  initial begin
    forever begin
      @(negedge clk);
      #4;
      while (q_req.size() > 0) begin
        string      r;
        logic [4:0] e;
        logic [4:0] a;
        r = q_req.pop_front();
        e = q_val.pop_front();
        a = {boot_state, ack_en, reset_accepted, resp_pending};
        checks++;
        if (a !== e) begin
          fails++;
          $display("FAIL %s cycle %0d: {state,ack,acc,pend} actual=%b expected=%b",
                   r, now, a, e);
        end
      end
    end
  end

  task automatic want(input string r, input logic [1:0] st, input bit ack,
                      input bit acc, input bit pend);
    q_req.push_back(r);
    q_val.push_back({st, ack, acc, pend});
  endtask

  task automatic step(input bit v, input logic [1:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = v;
    ev_kind  = k;
    ev_byte  = b;
    now++;
  endtask

  task automatic idle();
    step(1'b0, K_START, 8'h00);
  endtask

  task automatic idle_until(input int t);
    while (now < t) idle();
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] d [6], input int n);
    step(1'b1, K_START, 8'h00);
    step(1'b1, K_ADDR, a);
    for (int i = 0; i < n; i++) step(1'b1, K_DATA, d[i]);
    step(1'b1, K_STOP, 8'h00);
  endtask

  task automatic en_cycle(output int c);
    @(negedge clk);
    boot_en = 1'b0;
    ev_valid = 1'b0;
    now++;
    @(negedge clk);
    boot_en = 1'b1;
    now++;
    c = now;
  endtask

  logic [7:0] good [6];
  logic [7:0] bad  [6];
  logic [7:0] lng  [6];
  int c1, c2, c3, c4;

  initial begin
    good = '{8'h20, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};
    bad  = '{8'h20, 8'h00, 8'h01, 8'h02, 8'h00, 8'h00};
    lng  = '{8'h20, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00};
    rst_n = 1'b0; boot_en = 1'b0; addr_sel = 1'b0;
    ev_valid = 1'b0; ev_kind = K_START; ev_byte = 8'h00;

    idle(); want("R1", 2'd0, 0, 0, 0);
    idle();
    rst_n = 1'b1;
    step(1'b1, K_ADDR, 8'h50); want("R1", 2'd0, 0, 0, 0);

    // R2: enable rises
    @(negedge clk); boot_en = 1'b1; ev_valid = 1'b0; now++; c1 = now;
    idle(); want("R2", 2'd1, 0, 0, 0);

    // R3: address decode with strap low
    step(1'b1, K_ADDR, 8'h50); want("R3", 2'd1, 1, 0, 0);
    step(1'b1, K_ADDR, 8'h52); want("R3", 2'd1, 0, 0, 0);
    step(1'b1, K_ADDR, 8'h51); want("R3", 2'd1, 1, 0, 0);
    step(1'b1, K_STOP, 8'h00);

    // R5: rejected transfers
    send(8'h50, bad, 4);  idle(); want("R5 wrong byte", 2'd1, 0, 0, 0);
    send(8'h50, good, 3); idle(); want("R5 short", 2'd1, 0, 0, 0);
    send(8'h50, lng, 5);  idle(); want("R5 long", 2'd1, 0, 0, 0);
    send(8'h52, good, 4); idle(); want("R5 other address", 2'd1, 0, 0, 0);
    send(8'h51, good, 4); idle(); want("R5 read bit", 2'd1, 0, 0, 0);
    step(1'b1, K_START, 8'h00);
    step(1'b1, K_ADDR, 8'h50);
    step(1'b1, K_DATA, 8'h20);
    step(1'b1, K_DATA, 8'h00);
    step(1'b1, K_START, 8'h00);
    step(1'b1, K_ADDR, 8'h50);
    step(1'b1, K_DATA, 8'h01);
    step(1'b1, K_DATA, 8'h01);
    step(1'b1, K_STOP, 8'h00);
    idle(); want("R5 split by restart", 2'd1, 0, 0, 0);

    // R6: window length unchanged by rejected traffic
    idle_until(c1 + W); want("R6 last wait cycle", 2'd1, 0, 0, 0);
    idle(); want("R6 power-down", 2'd3, 0, 0, 0);

    // R7: power-down ignores the bus
    step(1'b1, K_ADDR, 8'h50); want("R7 no ack", 2'd3, 0, 0, 0);
    send(8'h50, good, 4); idle(); want("R7 command ignored", 2'd3, 0, 0, 0);
    repeat (W + 20) idle();
    want("R7 sticky", 2'd3, 0, 0, 0);

    // R8: enable cycle leaves power-down
    @(negedge clk); boot_en = 1'b0; ev_valid = 1'b0; now++;
    @(negedge clk); boot_en = 1'b1; now++; c2 = now;
    want("R8 off", 2'd0, 0, 0, 0);
    idle(); want("R8 wait", 2'd1, 0, 0, 0);

    // R4: valid command
    send(8'h50, good, 4);
    idle(); want("R4 accept", 2'd2, 0, 1, 1);
    idle(); want("R4 pulse ends", 2'd2, 0, 0, 1);
    step(1'b1, K_ADDR, 8'h50); want("R3 ready ack", 2'd2, 1, 0, 1);
    idle(); want("R9 write keeps pending", 2'd2, 0, 0, 1);
    send(8'h50, good, 4);
    idle(); want("R11 no second accept", 2'd2, 0, 0, 1);
    idle_until(c2 + W + 5); want("R4 ready persists", 2'd2, 0, 0, 1);
    step(1'b1, K_ADDR, 8'h51); want("R9 read ack", 2'd2, 1, 0, 1);
    idle(); want("R9 pending cleared", 2'd2, 0, 0, 0);

    // R10: stop in last window cycle, strap high
    @(negedge clk); boot_en = 1'b0; addr_sel = 1'b1; ev_valid = 1'b0; now++;
    @(negedge clk); boot_en = 1'b1; now++; c3 = now;
    idle();
    step(1'b1, K_ADDR, 8'h52); want("R3 strap high", 2'd1, 1, 0, 0);
    step(1'b1, K_ADDR, 8'h50); want("R3 strap high other", 2'd1, 0, 0, 0);
    idle_until(c3 + W - 7);
    step(1'b1, K_START, 8'h00);
    step(1'b1, K_ADDR, 8'h52);
    for (int i = 0; i < 4; i++) step(1'b1, K_DATA, good[i]);
    step(1'b1, K_STOP, 8'h00); want("R10 stop on last cycle", 2'd1, 0, 0, 0);
    idle(); want("R10 accepted at deadline", 2'd2, 0, 1, 1);

    // R10: stop one cycle late
    en_cycle(c4);
    idle_until(c4 + W - 6);
    step(1'b1, K_START, 8'h00);
    step(1'b1, K_ADDR, 8'h52);
    for (int i = 0; i < 4; i++) step(1'b1, K_DATA, good[i]);
    step(1'b1, K_STOP, 8'h00); want("R6 expired before stop", 2'd3, 0, 0, 0);
    idle(); want("R10 late stop ignored", 2'd3, 0, 0, 0);

    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run actual=hung expected=complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule